// File: doc/BRIEF.md
# Framed Nibble Bus Target Front End

This block is the target side of a clocked, 4-bit multiplexed bus. An active-low frame strobe marks the start of an operation. A 4-bit lane carries a fixed sequence of nibbles: a command, a target identity, the address, and then, for a write, the data. The block compares the identity nibble against a 4-bit strap. When they match, it collects the address and raises a one-cycle internal request. For a read, it then drives the returned data back onto the lane during its own response phase.

The frame strobe also cancels work in progress. If the strobe is sampled low while an operation is under way, the block returns to idle on that same edge. Any partial request is discarded and the lane is released. Two active-low reset inputs combine into one internal reset: the block is held in reset whenever either input is low. While reset is active, the block also samples an interface-mode select input. That selection then stays frozen until the next reset. When the alternate mode is selected, this front end stays passive.

The lane is modelled as separate input, output and output-enable signals, ready for a pad-level tristate buffer. The parameter `ADDR_NIB` sets the number of address nibbles and `DATA_NIB` sets the number of data nibbles.

Top module: `nib_target`

## Requirements
- R1: With the block idle or passive and `alt_mode` low, `frame_n` sampled low on a rising edge starts an operation. On that edge, `lane_in` bit 0 gives the direction: 1 means write and 0 means read.
- R2: The nibble on the edge after the start is compared with `id_strap`. On a mismatch, the block raises no request and never drives `lane_oe` until the next frame start.
- R3: Address nibbles arrive most significant first, `ADDR_NIB` of them. For a write, `DATA_NIB` data nibbles follow, least significant first. One cycle after the last data nibble is sampled, `req_valid` is high for exactly one cycle, with `req_write`=1 and the collected address and data.
- R4: For a read, `req_valid` is high for one cycle after the last address nibble is sampled, with `req_write`=0. `rsp_rdata` is captured at the end of that cycle. `lane_oe` is then high for exactly `DATA_NIB` cycles, and `lane_out` presents the data least significant nibble first.
- R5: `frame_n` sampled low in any state other than idle or passive aborts the operation. The block goes to idle on that edge, so in the next cycle `req_valid` and `lane_oe` are both low, and no request follows.
- R6: The block enters reset asynchronously when `rst_a_n` or `rst_b_n` is low. While in reset, `lane_oe` and `req_valid` are low. On leaving reset, the block is idle and ready to accept a read.
- R7: `alt_mode` takes the value of `mode_sel` on every rising edge at which reset is active. Changes to `mode_sel` outside reset have no effect.
- R8: While `alt_mode` is 1, frame starts are ignored: no request is raised and the lane is never driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_a_n | input | 1 | Interface reset, active low |
| rst_b_n | input | 1 | Host reset, active low |
| mode_sel | input | 1 | Interface-mode select, sampled during reset |
| id_strap | input | 4 | Strapped target identity |
| frame_n | input | 1 | Frame strobe, active low |
| lane_in | input | 4 | Lane value seen at the pins |
| lane_out | output | 4 | Value driven onto the lane |
| lane_oe | output | 1 | Lane output enable |
| req_valid | output | 1 | One-cycle internal request strobe |
| req_write | output | 1 | Request direction, 1 for write |
| req_addr | output | 4*ADDR_NIB | Collected address |
| req_wdata | output | 4*DATA_NIB | Collected write data |
| rsp_rdata | input | 4*DATA_NIB | Read data, captured the cycle after a read request |
| alt_mode | output | 1 | Latched interface mode |

## Verification
The bench builds the block with `ADDR_NIB`=4 and `DATA_NIB`=2 and straps the identity to 4'hA. With these values a read takes nine frame steps and a write takes eight. An abort can therefore be placed at every step of each operation: in the identity phase, in each address nibble, in the read-latch cycle and in both drive cycles. The read data is a function of the address, which exposes any swap in nibble order on either path.

// File: rtl/nib_target.sv
module nib_target #(
  parameter int ADDR_NIB = 8,
  parameter int DATA_NIB = 2
) (
  input  logic                  clk,
  input  logic                  rst_a_n,
  input  logic                  rst_b_n,
  input  logic                  mode_sel,
  input  logic [3:0]            id_strap,
  input  logic                  frame_n,
  input  logic [3:0]            lane_in,
  output logic [3:0]            lane_out,
  output logic                  lane_oe,
  output logic                  req_valid,
  output logic                  req_write,
  output logic [4*ADDR_NIB-1:0] req_addr,
  output logic [4*DATA_NIB-1:0] req_wdata,
  input  logic [4*DATA_NIB-1:0] rsp_rdata,
  output logic                  alt_mode
);
  localparam int AW = 4 * ADDR_NIB;
  localparam int DW = 4 * DATA_NIB;
  localparam int MAXN = (ADDR_NIB > DATA_NIB) ? ADDR_NIB : DATA_NIB;
  localparam int CW = $clog2(MAXN + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_IDCHK, S_ADDR, S_WDAT, S_RLAT, S_RDRV, S_PASSIVE
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           is_wr;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata;
  logic [DW-1:0]  rbuf;
  logic           mode_q;
  logic           rst_n;

  assign rst_n     = rst_a_n & rst_b_n;
  assign lane_oe   = (st == S_RDRV);
  assign lane_out  = lane_oe ? rbuf[3:0] : 4'h0;
  assign req_addr  = addr;
  assign req_wdata = wdata;
  assign alt_mode  = mode_q;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      addr      <= '0;
      wdata     <= '0;
      rbuf      <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (st == S_IDLE || st == S_PASSIVE) begin
        if (!frame_n && !mode_q) begin
          is_wr <= lane_in[0];
          st    <= S_IDCHK;
        end
      end else if (!frame_n) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          S_IDCHK: begin
            cnt <= '0;
            st  <= (lane_in == id_strap) ? S_ADDR : S_PASSIVE;
          end
          S_ADDR: begin
            addr <= {addr[AW-5:0], lane_in};
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(ADDR_NIB - 1)) begin
              cnt <= '0;
              if (is_wr) st <= S_WDAT;
              else begin
                st        <= S_RLAT;
                req_valid <= 1'b1;
                req_write <= 1'b0;
              end
            end
          end
          S_WDAT: begin
            wdata <= DW'({lane_in, wdata} >> 4);
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(DATA_NIB - 1)) begin
              cnt       <= '0;
              st        <= S_IDLE;
              req_valid <= 1'b1;
              req_write <= 1'b1;
            end
          end
          S_RLAT: begin
            rbuf <= rsp_rdata;
            cnt  <= '0;
            st   <= S_RDRV;
          end
          S_RDRV: begin
            rbuf <= rbuf >> 4;
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(DATA_NIB - 1)) begin
              cnt <= '0;
              st  <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module nib_target_chk (
  input logic clk,
  input logic rst_a_n,
  input logic rst_b_n,
  input logic frame_n,
  input logic lane_oe,
  input logic req_valid,
  input logic req_write,
  input logic alt_mode
);
  logic rn;
  assign rn = rst_a_n & rst_b_n;

  a_r5_abort_release: assert property (@(posedge clk) disable iff (!rn)
    !frame_n |=> (!lane_oe && !req_valid));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rn)
    req_valid |=> !req_valid);

  a_r4_drive_after_read: assert property (@(posedge clk) disable iff (!rn)
    $rose(lane_oe) |-> ($past(req_valid) && !$past(req_write)));

  a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (!rn)
    $rose(rn) |-> (!lane_oe && !req_valid));

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rn)
    $past(rn) |-> $stable(alt_mode));

  a_r8_alt_passive: assert property (@(posedge clk) disable iff (!rn)
    alt_mode |-> (!lane_oe && !req_valid));
endmodule

bind nib_target nib_target_chk u_chk (
  .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .frame_n(frame_n),
  .lane_oe(lane_oe), .req_valid(req_valid), .req_write(req_write),
  .alt_mode(alt_mode)
);

// File: tb/nib_target_test.sv
module nib_target_test;
  localparam int PERIOD = 10;
  localparam int AN = 4;
  localparam int DN = 2;
  localparam int AW = 4 * AN;
  localparam int DW = 4 * DN;
  localparam logic [3:0] ID = 4'hA;

  logic clk = 0;
  logic rst_a_n = 0, rst_b_n = 0, mode_sel = 0, frame_n = 1;
  logic [3:0] lane_in = 0;
  logic [3:0] lane_out;
  logic lane_oe, req_valid, req_write, alt_mode;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;

  always #(PERIOD/2) clk = ~clk;

  assign rsp_rdata = DW'(req_addr * 3 + 16'h17);

  nib_target #(.ADDR_NIB(AN), .DATA_NIB(DN)) uut (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .mode_sel(mode_sel),
    .id_strap(ID), .frame_n(frame_n), .lane_in(lane_in), .lane_out(lane_out),
    .lane_oe(lane_oe), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .alt_mode(alt_mode)
  );

  int nchk = 0, nerr = 0, nreq = 0, noe = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: ph 0 idle, 1 id, 2 addr, 3 wdata, 4 rlatch, 5 drive, 6 passive
  int ph = 0, mc = 0;
  bit mw = 0, ev = 0, ew = 0, emode = 0;
  logic [AW-1:0] ma = 0, ea = 0;
  logic [DW-1:0] mwd = 0, ewd = 0, mrb = 0;

  always @(posedge clk)
    if (!(rst_a_n && rst_b_n)) emode = mode_sel;

  always @(posedge clk or negedge rst_a_n or negedge rst_b_n) begin
    if (!(rst_a_n && rst_b_n)) begin
      ph = 0; mc = 0; ev = 0;
    end else begin
      ev = 0;
      if (ph == 0 || ph == 6) begin
        if (!frame_n && !emode) begin mw = lane_in[0]; ph = 1; end
      end else if (!frame_n) ph = 0;
      else begin
        case (ph)
          1: if (lane_in == ID) begin ph = 2; mc = 0; ma = 0; end else ph = 6;
          2: begin
            ma = AW'((ma << 4) | lane_in); mc++;
            if (mc == AN) begin
              mc = 0;
              if (mw) begin ph = 3; mwd = 0; end
              else begin ph = 4; ev = 1; ew = 0; ea = ma; end
            end
          end
          3: begin
            mwd = mwd | (DW'(lane_in) << (4 * mc)); mc++;
            if (mc == DN) begin ev = 1; ew = 1; ea = ma; ewd = mwd; ph = 0; mc = 0; end
          end
          4: begin mrb = DW'(ma * 3 + 16'h17); ph = 5; mc = 0; end
          5: begin mc++; if (mc == DN) begin ph = 0; mc = 0; end end
          default: ph = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    logic eoe;
    eoe = (ph == 5);
    chk(lane_oe === eoe, "R4/R5 lane_oe", lane_oe, eoe);
    if (eoe) chk(lane_out === 4'((mrb >> (4 * mc)) & 4'hF), "R4 lane_out", lane_out, (mrb >> (4 * mc)) & 4'hF);
    chk(req_valid === ev, "R3/R5 req_valid", req_valid, ev);
    if (ev) begin
      chk(req_write === ew, "R1 req_write", req_write, ew);
      chk(req_addr === ea, "R3 req_addr", req_addr, ea);
      if (ew) chk(req_wdata === ewd, "R3 req_wdata", req_wdata, ewd);
    end
    if (rst_a_n && rst_b_n) chk(alt_mode === emode, "R7 alt_mode", alt_mode, emode);
    if (req_valid) nreq++;
    if (lane_oe) noe++;
  end

  task automatic step(input logic f, input logic [3:0] n);
    @(posedge clk); #1;
    frame_n = f; lane_in = n;
  endtask

  // abort_at < 0 means no abort
  task automatic op(input bit wr, input logic [3:0] id, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input int abort_at);
    logic [3:0] q[$];
    q.push_back({3'b000, wr});
    q.push_back(id);
    for (int i = AN - 1; i >= 0; i--) q.push_back(a[4*i +: 4]);
    if (wr) for (int i = 0; i < DN; i++) q.push_back(d[4*i +: 4]);
    else for (int i = 0; i < DN + 1; i++) q.push_back(4'h0);
    for (int i = 0; i < q.size(); i++) begin
      if (i == abort_at) begin step(1'b0, 4'h0); break; end
      step(i == 0 ? 1'b0 : 1'b1, q[i]);
    end
    for (int i = 0; i < 3; i++) step(1'b1, 4'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int r0, o0;
    repeat (3) @(posedge clk);
    #1;
    chk(lane_oe === 1'b0 && req_valid === 1'b0, "R6 reset state", {lane_oe, req_valid}, 0);
    rst_a_n = 1; rst_b_n = 1;
    step(1'b1, 4'h0);
    chk(alt_mode === 1'b0, "R7 mode after reset", alt_mode, 0);

    r0 = nreq; o0 = noe;
    op(1'b0, ID, 16'h3C5A, 0, -1);
    chk(nreq - r0 == 1 && noe - o0 == DN, "R4 read issues request and drives", {nreq - r0, noe - o0}, {32'd1, 32'(DN)});

    r0 = nreq;
    op(1'b1, ID, 16'hB271, 8'h9E, -1);
    chk(nreq - r0 == 1, "R1 write issues request", nreq - r0, 1);

    r0 = nreq; o0 = noe;
    op(1'b0, 4'h3, 16'h1111, 0, -1);
    chk(nreq == r0 && noe == o0, "R2 identity mismatch passive", {nreq - r0, noe - o0}, 0);

    for (int k = 1; k < 2 + AN + 1 + DN; k++) begin
      r0 = nreq;
      op(1'b0, ID, 16'h4000 + 16'(k), 0, k);
      chk(nreq - r0 == (k >= 2 + AN ? 1 : 0), "R5 read abort", nreq - r0, k >= 2 + AN);
    end
    for (int k = 1; k < 2 + AN + DN; k++) begin
      r0 = nreq;
      op(1'b1, ID, 16'h5000 + 16'(k), 8'h66, k);
      chk(nreq == r0, "R5 write abort", nreq - r0, 0);
    end

    // reset in the middle of the drive phase
    fork
      op(1'b0, ID, 16'h0F0F, 0, -1);
      begin
        repeat (2 + AN + 2) @(posedge clk);
        #2 rst_b_n = 0;
        #1 chk(lane_oe === 1'b0 && req_valid === 1'b0, "R6 mid-op reset", {lane_oe, req_valid}, 0);
      end
    join
    mode_sel = 1;
    step(1'b1, 4'h0);
    step(1'b1, 4'h0);
    rst_b_n = 1;
    step(1'b1, 4'h0);
    mode_sel = 0;
    step(1'b1, 4'h0);
    chk(alt_mode === 1'b1, "R7 mode captured in reset", alt_mode, 1);
    r0 = nreq; o0 = noe;
    op(1'b0, ID, 16'h2222, 0, -1);
    chk(nreq == r0 && noe == o0, "R8 alternate mode passive", {nreq - r0, noe - o0}, 0);
    chk(alt_mode === 1'b1, "R7 mode ignores change outside reset", alt_mode, 1);

    rst_a_n = 0;
    step(1'b1, 4'h0);
    rst_a_n = 1;
    step(1'b1, 4'h0);
    chk(alt_mode === 1'b0, "R7 mode recaptured", alt_mode, 0);
    r0 = nreq; o0 = noe;
    op(1'b0, ID, 16'hFEDC, 0, -1);
    chk(nreq - r0 == 1 && noe - o0 == DN, "R6 read after reset", {nreq - r0, noe - o0}, {32'd1, 32'(DN)});

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule